// File: doc/BRIEF.md
# DAC Waveform Output Selector

This block picks the sample data that goes to a DAC for an in-phase (I) and a quadrature (Q) channel. The fabric clock runs at a quarter of the converter's sample rate, so every source offers four sample lanes per channel on each fabric clock, and the block forwards one four-lane word per channel per clock. The sources are a DDS sine, a ramp, a triangle, a pulse/square wave, an arbitrary waveform, a test pattern sequence and a fixed sine. The generators sit outside this block and reach it as plain inputs.

Each channel is chosen through a cascade of 2:1 multiplexers steered by bits of a 32-bit control word. Each channel has four steering bits at fixed, scattered positions. Two further bits are shared by both channels: a test-source bit and an output enable. The output enable is the last stage of the cascade and forces zero samples when it is clear. A control word of zero selects the DDS sine on both channels with the output disabled. The output register is the only pipeline stage.

Top module: `dac_wave_select`

## Requirements
- R1: While `rst_n` is low, `dac_i` and `dac_q` are all zero.
- R2: When control bit 0 (output enable) is 0, both outputs are all zero on the next clock, whatever the other control bits and sources are.
- R3: The outputs show the selection made from the inputs present at the previous rising clock edge. All four lanes of a channel come from the same source in the same cycle, and lane k of the output is lane k of that source.
- R4: With the enable set and all four steering bits of a channel at 0, that channel outputs the DDS sine.
- R5: On the normal path the I channel decodes {bit 3, bit 2} as 00 DDS sine, 01 ramp, 10 triangle, 11 pulse/square.
- R6: I control bit 28 set, with bit 1 clear, selects the arbitrary waveform, which overrides the R5 code.
- R7: I control bit 1 set selects the test path, which overrides bit 28 and the R5 code.
- R8: Shared control bit 8 picks the test source: 0 is the pattern sequence and 1 is the fixed sine.
- R9: The Q channel uses bit 5 (test), bit 29 (arbitrary), bit 7 (code high) and bit 6 (code low) with the same meaning as the I bits. The I and Q selections are independent of each other.
- R10: Control bits other than 0, 1, 2, 3, 5, 6, 7, 8, 28 and 29 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 32 | Control word holding the steering, test-source and enable bits |
| sine_i | input | 64 | DDS sine, I, four 16-bit lanes (lane 0 in the low bits) |
| ramp_i | input | 64 | Ramp, I |
| trgl_i | input | 64 | Triangle, I |
| pulse_i | input | 64 | Pulse/square, I |
| arb_i | input | 64 | Arbitrary waveform, I |
| pat_i | input | 64 | Test pattern sequence, I |
| fsin_i | input | 64 | Fixed sine, I |
| sine_q | input | 64 | DDS sine, Q |
| ramp_q | input | 64 | Ramp, Q |
| trgl_q | input | 64 | Triangle, Q |
| pulse_q | input | 64 | Pulse/square, Q |
| arb_q | input | 64 | Arbitrary waveform, Q |
| pat_q | input | 64 | Test pattern sequence, Q |
| fsin_q | input | 64 | Fixed sine, Q |
| dac_i | output | 64 | Registered I samples to the DAC |
| dac_q | output | 64 | Registered Q samples to the DAC |

## Verification
The bench puts new random data on every source lane each cycle, so a wrong source, a swapped lane or an extra pipeline stage shows up as a mismatch against the reference model. It walks both channels through every steering code and then combines the test, arbitrary and code bits, so a cascade built in the wrong order, where the arbitrary bit beats the test bit or the code bits leak through, gives the wrong source. It turns off the enable under busy selections to catch gating that is not the last stage. It also sets every bit that is meant to be ignored, and sets the I bits while Q is being exercised, to catch a decoder wired to the wrong or to neighbouring bit positions.

// File: rtl/dac_wave_select.sv
module dac_wave_select #(
  parameter int SW         = 16,
  parameter int LANES      = 4,
  parameter int EN_BIT     = 0,
  parameter int TSRC_BIT   = 8,
  parameter int I_TEST_BIT = 1,
  parameter int I_ARB_BIT  = 28,
  parameter int I_HI_BIT   = 3,
  parameter int I_LO_BIT   = 2,
  parameter int Q_TEST_BIT = 5,
  parameter int Q_ARB_BIT  = 29,
  parameter int Q_HI_BIT   = 7,
  parameter int Q_LO_BIT   = 6,
  localparam int W = SW * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  ctrl,
  input  logic [W-1:0] sine_i,
  input  logic [W-1:0] ramp_i,
  input  logic [W-1:0] trgl_i,
  input  logic [W-1:0] pulse_i,
  input  logic [W-1:0] arb_i,
  input  logic [W-1:0] pat_i,
  input  logic [W-1:0] fsin_i,
  input  logic [W-1:0] sine_q,
  input  logic [W-1:0] ramp_q,
  input  logic [W-1:0] trgl_q,
  input  logic [W-1:0] pulse_q,
  input  logic [W-1:0] arb_q,
  input  logic [W-1:0] pat_q,
  input  logic [W-1:0] fsin_q,
  output logic [W-1:0] dac_i,
  output logic [W-1:0] dac_q
);

  function automatic logic [W-1:0] cascade(
    input logic t, a, h, l, fs,
    input logic [W-1:0] sine, ramp, trgl, pulse, arb, pat, fsin);
    logic [W-1:0] lo_pair, hi_pair, norm, with_arb, test;
    lo_pair  = l ? ramp  : sine;
    hi_pair  = l ? pulse : trgl;
    norm     = h ? hi_pair : lo_pair;
    with_arb = a ? arb : norm;
    test     = fs ? fsin : pat;
    return t ? test : with_arb;
  endfunction

  logic         en, fs;
  logic [W-1:0] nxt_i, nxt_q;

  assign en = ctrl[EN_BIT];
  assign fs = ctrl[TSRC_BIT];

  assign nxt_i = cascade(ctrl[I_TEST_BIT], ctrl[I_ARB_BIT], ctrl[I_HI_BIT], ctrl[I_LO_BIT], fs,
                         sine_i, ramp_i, trgl_i, pulse_i, arb_i, pat_i, fsin_i);
  assign nxt_q = cascade(ctrl[Q_TEST_BIT], ctrl[Q_ARB_BIT], ctrl[Q_HI_BIT], ctrl[Q_LO_BIT], fs,
                         sine_q, ramp_q, trgl_q, pulse_q, arb_q, pat_q, fsin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_i <= '0;
      dac_q <= '0;
    end else begin
      dac_i <= en ? nxt_i : '0;
      dac_q <= en ? nxt_q : '0;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (dac_i == '0 && dac_q == '0));

  // R2
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[EN_BIT] |=> (dac_i == '0 && dac_q == '0));

  // R4
  default_sine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[EN_BIT] && !ctrl[I_TEST_BIT] && !ctrl[I_ARB_BIT] && !ctrl[I_HI_BIT] && !ctrl[I_LO_BIT])
    |=> dac_i == $past(sine_i));

  // R6
  arb_over_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[EN_BIT] && !ctrl[I_TEST_BIT] && ctrl[I_ARB_BIT]) |=> dac_i == $past(arb_i));

  // R7
  test_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[EN_BIT] && ctrl[I_TEST_BIT] && !ctrl[TSRC_BIT]) |=> dac_i == $past(pat_i));

  // R9
  q_fixed_sine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[EN_BIT] && ctrl[Q_TEST_BIT] && ctrl[TSRC_BIT]) |=> dac_q == $past(fsin_q));

endmodule

// File: tb/dac_wave_select_tb.sv
`timescale 1ns/1ps
module dac_wave_select_tb;
  localparam int W = 64;
  localparam logic [31:0] USED = 32'h3000_01EF;

  logic clk = 0, rst_n = 0;
  logic [31:0] ctrl = '0;
  logic [W-1:0] src_i [7];
  logic [W-1:0] src_q [7];
  logic [W-1:0] dac_i, dac_q;
  logic [W-1:0] exp_i, exp_q;
  bit have_exp = 0, done = 0;
  string prev_tag = "R1";
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dac_wave_select u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .sine_i(src_i[0]), .ramp_i(src_i[1]), .trgl_i(src_i[2]), .pulse_i(src_i[3]),
    .arb_i(src_i[4]), .pat_i(src_i[5]), .fsin_i(src_i[6]),
    .sine_q(src_q[0]), .ramp_q(src_q[1]), .trgl_q(src_q[2]), .pulse_q(src_q[3]),
    .arb_q(src_q[4]), .pat_q(src_q[5]), .fsin_q(src_q[6]),
    .dac_i(dac_i), .dac_q(dac_q));

  // index into src: 0 sine 1 ramp 2 triangle 3 pulse 4 arb 5 pattern 6 fixed sine, -1 zero
  function automatic int model(input logic [31:0] c, input int tb, ab, hb, lb);
    if (!c[0]) return -1;
    if (c[tb]) return c[8] ? 6 : 5;
    if (c[ab]) return 4;
    return 2 * int'(c[hb]) + int'(c[lb]);
  endfunction

  task automatic check(input string tag, input string ch, input logic [W-1:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, ch, act, exp_v);
    end
  endtask

  task automatic step(input logic [31:0] c, input string tag);
    int si, sq;
    @(negedge clk);
    if (have_exp) begin
      check(prev_tag, "dac_i", dac_i, exp_i);
      check(prev_tag, "dac_q", dac_q, exp_q);
    end
    for (int k = 0; k < 7; k++) begin
      src_i[k] = {$urandom, $urandom};
      src_q[k] = {$urandom, $urandom};
    end
    ctrl = c;
    si = model(c, 1, 28, 3, 2);
    sq = model(c, 5, 29, 7, 6);
    exp_i = (si < 0) ? '0 : src_i[si];
    exp_q = (sq < 0) ? '0 : src_q[sq];
    have_exp = 1;
    prev_tag = tag;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 7; k++) begin
      src_i[k] = {$urandom, $urandom};
      src_q[k] = {$urandom, $urandom};
    end
    ctrl = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1", "dac_i", dac_i, '0);
    check("R1", "dac_q", dac_q, '0);
    ctrl = '0;
    rst_n = 1;
    // R2: enable clear
    step(32'h0, "R2");
    step(32'h0, "R2");
    // R4: default sine on both
    step(32'h1, "R4");
    step(32'h1, "R4");
    // R5: I code walk, R9: Q code walk
    for (int k = 0; k < 4; k++) step(32'h1 | (k << 2), "R5");
    for (int k = 0; k < 4; k++) step(32'h1 | (k << 6) | ((3 - k) << 2), "R9");
    // R6: arbitrary beats code
    for (int k = 0; k < 4; k++) step(32'h1000_0001 | (k << 2), "R6");
    step(32'h2000_0001 | (32'h3 << 6), "R9");
    // R7 / R8: test path beats arbitrary and code
    step(32'h1000_000F, "R7");
    step(32'h1000_010F, "R8");
    step(32'h3 , "R8");
    step(32'h103, "R8");
    step(32'h2000_00E1, "R9");
    step(32'h2000_01E1, "R9");
    step(32'h3000_01EF, "R7");
    // R2: enable off under busy selections
    step(32'hFFFF_FFFE, "R2");
    step(32'h3000_01EE, "R2");
    // R10: unused bits set
    for (int k = 0; k < 16; k++) step(({$urandom} & USED) | ~USED | 32'h1, "R10");
    step(~USED | 32'h1, "R10");
    // R3: random selections, lanes and latency every cycle
    for (int k = 0; k < 300; k++) step($urandom, "R3");
    step(32'h0, "R2");
    @(negedge clk);
    check(prev_tag, "dac_i", dac_i, exp_i);
    check(prev_tag, "dac_q", dac_q, exp_q);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule